// File: doc/BRIEF.md
# Store/Recall Sequence Detector

This block watches the control and address lines of an asynchronous static-memory bus. It recognises the fixed, ordered run of six read cycles that asks the memory to copy its contents into nonvolatile cells (store) or to reload them from those cells (recall). The chip-enable line is asynchronous to the system clock. The block therefore synchronises it and turns each falling edge into a single strobe in the clock domain. On that strobe the block samples the write-enable level and the address.

The first five addresses are the same for both requests. The sixth address chooses between store and recall. When the sixth address matches, the block issues a one-cycle request pulse and returns to idle. A write, a wrong address or a repeated edge that does not follow the order drops the attempt. A wrong address that equals the first address of the sequence starts a new attempt at step one. While the nonvolatile engine reports busy, bus cycles are ignored. The detector returns to idle when busy falls. The `busy` input is synchronous to `clk`.

Top module: `nvseq_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `seq_step` is 0 and both request outputs are low.
- R2: After the first five addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order, a read at 0x0FC0 raises `store_req` for exactly one clock cycle and returns `seq_step` to 0.
- R3: After the same five addresses, a read at 0x0C63 raises `recall_req` for exactly one clock cycle and returns `seq_step` to 0. The two request outputs are never high together.
- R4: `seq_step` equals the number of addresses matched in order so far, from 0 to 5.
- R5: An address that is not the expected next one returns `seq_step` to 0. If that address is 0x0E38, `seq_step` becomes 1 instead. A final address at any step other than 5 requests nothing.
- R6: A repeated chip-enable cycle that presents the same address again (double clocking) aborts the attempt. At step 1 such a repeat restarts the attempt, so `seq_step` stays at 1.
- R7: A cycle sampled with `we_n` low sets `seq_step` to 0, even when its address matches.
- R8: Only `addr[13:0]` is compared. Bit 14 has no effect on matching or on the requests.
- R9: While `busy` is high, bus cycles neither change `seq_step` nor raise a request.
- R10: On the clock after `busy` falls, `seq_step` is 0.
- R11: A falling edge of `ce_n` counts once, however long `ce_n` then stays low. The edge passes through a two-flop synchronizer before it is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Memory chip enable, active low, asynchronous |
| we_n | input | 1 | Memory write enable, active low, sampled with the edge |
| addr | input | 15 | Memory address; only the low 14 bits are compared |
| busy | input | 1 | Nonvolatile transfer in progress, synchronous to `clk` |
| store_req | output | 1 | One-cycle pulse requesting a store |
| recall_req | output | 1 | One-cycle pulse requesting a recall |
| seq_step | output | 3 | Number of sequence addresses matched so far |

## Verification
Every state change appears on `seq_step` at the third rising clock edge after `ce_n` is first sampled low. A wrong step count is therefore visible at the ports one cycle after the edge that caused it, well before the next bus cycle. A wrong state that survives to the sixth cycle also shows up as a missing, extra or wrongly chosen request pulse. That is why the bench counts request cycles and reads `seq_step` after every bus cycle. Busy handling is checked from step 5, where a missed hold would fire a request at once.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int CMP_W    = 14;
  localparam int PREFIX_N = 5;
  localparam int STEP_W   = $clog2(PREFIX_N + 1);

  typedef logic [CMP_W-1:0]  cmp_addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam cmp_addr_t STORE_ADDR  = 14'h0FC0;
  localparam cmp_addr_t RECALL_ADDR = 14'h0C63;
  localparam step_t     LAST_STEP   = step_t'(PREFIX_N);

  // address expected at a given prefix position (order is behaviour)
  function automatic cmp_addr_t prefix_addr(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      4:       return 14'h303F;
      default: return '0;
    endcase
  endfunction

  // step reached after a mismatch: a fresh attempt if it is the opener
  function automatic step_t restart_step(input cmp_addr_t a);
    return (a == prefix_addr(0)) ? step_t'(1) : step_t'(0);
  endfunction

endpackage

// File: rtl/nvseq_edge_sync.sv
module nvseq_edge_sync #(
  parameter int DATA_W = 15,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [DATA_W-1:0] data_in,
  output logic              strobe,
  output logic [DATA_W-1:0] data_out
);

  logic              ce_pipe   [STAGES];
  logic [DATA_W-1:0] data_pipe [STAGES];
  logic              ce_last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ce_pipe[i]   <= 1'b1;
          data_pipe[i] <= '0;
        end else begin
          ce_pipe[i]   <= ce_n;
          data_pipe[i] <= data_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ce_pipe[i]   <= 1'b1;
          data_pipe[i] <= '0;
        end else begin
          ce_pipe[i]   <= ce_pipe[i-1];
          data_pipe[i] <= data_pipe[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_last <= 1'b1;
    else        ce_last <= ce_pipe[STAGES-1];
  end

  assign strobe   = ce_last & ~ce_pipe[STAGES-1];
  assign data_out = data_pipe[STAGES-1];

  // R11: one strobe per falling edge
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/nvseq_match.sv
module nvseq_match
  import nvseq_pkg::*;
(
  input  cmp_addr_t addr,
  input  step_t     step,
  output step_t     next_step,
  output logic      hit_store,
  output logic      hit_recall
);

  logic [PREFIX_N-1:0] hit;

  for (genvar i = 0; i < PREFIX_N; i++) begin : g_hit
    assign hit[i] = (addr == prefix_addr(i));
  end

  always_comb begin
    hit_store  = 1'b0;
    hit_recall = 1'b0;
    next_step  = restart_step(addr);
    if (step < LAST_STEP) begin
      if (hit[step]) next_step = step_t'(step + step_t'(1));
    end else if (addr == STORE_ADDR) begin
      hit_store = 1'b1;
      next_step = '0;
    end else if (addr == RECALL_ADDR) begin
      hit_recall = 1'b1;
      next_step  = '0;
    end
  end

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  logic  we_ok,
  input  logic  busy,
  input  step_t next_step,
  input  logic  hit_store,
  input  logic  hit_recall,
  output step_t step,
  output logic  store_req,
  output logic  recall_req
);

  logic busy_q;
  logic busy_fall;
  logic accept;

  assign busy_fall = busy_q & ~busy;
  assign accept    = strobe & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      busy_q     <= busy;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      if (busy_fall) begin
        step <= '0;
      end else if (accept) begin
        if (!we_ok) begin
          step <= '0;
        end else begin
          step       <= next_step;
          store_req  <= hit_store;
          recall_req <= hit_recall;
        end
      end
    end
  end

  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST_STEP);
  assert_store_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  assert_store_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> ($past(step) == LAST_STEP && step == '0));
  assert_recall_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> ($past(step) == LAST_STEP && step == '0));
  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req}));
  assert_write_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !busy && !we_ok) |=> step == '0);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(step) && !store_req && !recall_req));
  assert_busy_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy) |=> step == '0);

endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req,
  output logic [STEP_W-1:0] seq_step
);

  localparam int SAMPLE_W = CMP_W + 1;

  logic [SAMPLE_W-1:0] sample_in;
  logic [SAMPLE_W-1:0] sample_out;
  logic                strobe;
  step_t               step;
  step_t               next_step;
  logic                hit_store;
  logic                hit_recall;

  // R8: address bits above the compare field are dropped here
  if (ADDR_W > CMP_W) begin : g_upper
    logic unused_upper;
    assign unused_upper = ^addr[ADDR_W-1:CMP_W];
  end

  assign sample_in = {we_n, addr[CMP_W-1:0]};

  nvseq_edge_sync #(
    .DATA_W (SAMPLE_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .data_in  (sample_in),
    .strobe   (strobe),
    .data_out (sample_out)
  );

  nvseq_match u_match (
    .addr       (sample_out[CMP_W-1:0]),
    .step       (step),
    .next_step  (next_step),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  nvseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .we_ok      (sample_out[CMP_W]),
    .busy       (busy),
    .next_step  (next_step),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .step       (step),
    .store_req  (store_req),
    .recall_req (recall_req)
  );

  assign seq_step = step;

endmodule

// File: tb/test_nvseq_detect.sv
module test_nvseq_detect;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n;
  logic        we_n;
  logic [14:0] addr;
  logic        busy;
  logic        store_req;
  logic        recall_req;
  logic [2:0]  seq_step;

  int n_chk = 0;
  int n_bad = 0;
  int sto_cnt = 0;
  int rec_cnt = 0;

  always #10 clk = ~clk;

  nvseq_detect i_nvseq_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .busy(busy), .store_req(store_req), .recall_req(recall_req),
    .seq_step(seq_step)
  );

  // count high cycles of each request, sampled away from the active edge
  always @(negedge clk) begin
    if (store_req)  sto_cnt++;
    if (recall_req) rec_cnt++;
  end

  typedef struct packed {
    logic [14:0] a;
    logic        wr;
    logic [2:0]  st;
    logic        sto;
    logic        rec;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [14:0] P0 = 15'h0E38, P1 = 15'h31C7, P2 = 15'h03E0,
                          P3 = 15'h3C1F, P4 = 15'h303F, AS = 15'h0FC0,
                          AR = 15'h0C63;
  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2},  // R2 full store
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd2},
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd2},
    '{P3, 1'b0, 3'd4, 1'b0, 1'b0, 4'd2},
    '{P4, 1'b0, 3'd5, 1'b0, 1'b0, 4'd2},
    '{AS, 1'b0, 3'd0, 1'b1, 1'b0, 4'd2},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 full recall
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd3},
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd3},
    '{P3, 1'b0, 3'd4, 1'b0, 1'b0, 4'd3},
    '{P4, 1'b0, 3'd5, 1'b0, 1'b0, 4'd3},
    '{AR, 1'b0, 3'd0, 1'b0, 1'b1, 4'd3},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6},  // R6 double clock mid-sequence
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd6},
    '{P1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd6},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 opener restarts
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd5},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd5},
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd7},  // R7 write aborts
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd7},
    '{P3, 1'b1, 3'd0, 1'b0, 1'b0, 4'd7},
    '{P0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd7},
    '{15'h4E38, 1'b0, 3'd1, 1'b0, 1'b0, 4'd8},  // R8 bit 14 ignored
    '{15'h71C7, 1'b0, 3'd2, 1'b0, 1'b0, 4'd8},
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd8},
    '{P3, 1'b0, 3'd4, 1'b0, 1'b0, 4'd8},
    '{15'h703F, 1'b0, 3'd5, 1'b0, 1'b0, 4'd8},
    '{15'h4FC0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd8},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 out of order
    '{P2, 1'b0, 3'd0, 1'b0, 1'b0, 4'd5},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd4},  // R4 progress count
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd4},
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd4},
    '{P3, 1'b0, 3'd4, 1'b0, 1'b0, 4'd4},
    '{P4, 1'b0, 3'd5, 1'b0, 1'b0, 4'd4},
    '{P4, 1'b0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 repeat at last step
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6},  // R6 repeat at step 1 restarts
    '{P1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd5},
    '{P2, 1'b0, 3'd3, 1'b0, 1'b0, 4'd5},
    '{P3, 1'b0, 3'd4, 1'b0, 1'b0, 4'd5},
    '{P4, 1'b0, 3'd5, 1'b0, 1'b0, 4'd5},
    '{P0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 opener at step 5
    '{15'h1234, 1'b0, 3'd0, 1'b0, 1'b0, 4'd5},
    '{AS, 1'b0, 3'd0, 1'b0, 1'b0, 4'd5}   // R5 final address too early
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [14:0] a, input logic wr);
    @(negedge clk);
    addr = a; we_n = ~wr; ce_n = 1'b0;
    repeat (5) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s0, r0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset step", seq_step, 0);
    check("R1 reset store", store_req, 0);
    check("R1 reset recall", recall_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", seq_step, 0);

    for (int i = 0; i < NV; i++) begin
      s0 = sto_cnt; r0 = rec_cnt;
      bus_cycle(VEC[i].a, VEC[i].wr);
      check($sformatf("R%0d vec %0d step", VEC[i].rq, i), seq_step, VEC[i].st);
      check($sformatf("R%0d vec %0d store cycles", VEC[i].rq, i), sto_cnt - s0, VEC[i].sto);
      check($sformatf("R%0d vec %0d recall cycles", VEC[i].rq, i), rec_cnt - r0, VEC[i].rec);
    end

    // R11: long low chip enable counts once
    bus_cycle(P0, 1'b0);
    @(negedge clk); addr = P1; ce_n = 1'b0;
    repeat (20) @(negedge clk);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 held low counts once", seq_step, 2);
    bus_cycle(15'h0000, 1'b0);
    check("R5 clear", seq_step, 0);

    // R9 / R10: busy from step 5
    bus_cycle(P0, 1'b0); bus_cycle(P1, 1'b0); bus_cycle(P2, 1'b0);
    bus_cycle(P3, 1'b0); bus_cycle(P4, 1'b0);
    check("R4 at step 5", seq_step, 5);
    @(negedge clk); busy = 1'b1;
    s0 = sto_cnt; r0 = rec_cnt;
    bus_cycle(AS, 1'b0);
    check("R9 busy step held", seq_step, 5);
    check("R9 busy no store", sto_cnt - s0, 0);
    bus_cycle(AR, 1'b0);
    check("R9 busy no recall", rec_cnt - r0, 0);
    check("R9 busy step held again", seq_step, 5);
    @(negedge clk); busy = 1'b0;
    @(negedge clk);
    check("R10 idle after busy falls", seq_step, 0);
    s0 = sto_cnt;
    bus_cycle(AS, 1'b0);
    check("R10 no store after release", sto_cnt - s0, 0);

    // R1: reset mid-sequence
    bus_cycle(P0, 1'b0); bus_cycle(P1, 1'b0);
    check("R4 mid step", seq_step, 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-sequence", seq_step, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_cycle(P1, 1'b0);
    check("R1 no stale progress", seq_step, 0);

    finish_run();
  end

endmodule